// File: doc/BRIEF.md
# Seconds Timer with Alarm

This block keeps a free-running seconds count for an always-powered domain. A slow reference clock, typically 32.768 kHz, enters through a synchroniser. A programmable divider turns its rising edges into counter ticks, so a divide ratio of 32768 gives one tick per second. Software reads the count and can set a match value. It can enable a level interrupt for the match event, for every tick, or for both. It keeps a 32-bit time base of its own in a spare backup register. Calendar conversion and the offset arithmetic stay in software.

The counter cannot be loaded. Software can only clear it by writing a self-clearing restart bit in the mode word. All logic runs on the bus clock. The slow clock is sampled through a two-flop synchroniser. An edge detector state machine then sees it, with states EDGE_ARM, EDGE_LOW and EDGE_HIGH:
- Reset enters EDGE_ARM.
- EDGE_ARM moves to EDGE_LOW once the synchronised level is low, which stops a false edge after reset.
- EDGE_LOW moves to EDGE_HIGH on a high level and emits one edge pulse.
- EDGE_HIGH returns to EDGE_LOW on a low level.

All counter values seen by the bus are whole register values, never partial updates.

Top module: `sec_alarm_timer`

## Requirements
- R1: After reset the mode word reads 0x00008000, the match word reads 0xFFFFFFFF, and the count, status and backup words read 0. The irq output is low.
- R2: The count rises by exactly one for every P synchronised rising edges of slow_clk, where P is mode bits 15:0.
- R3: A divide field of 0 divides by 65536. Any write to the mode word restarts the divider from zero.
- R4: Writes to the count word (address 2) have no effect on the count.
- R5: Writing mode bit 18 as 1 clears the count and the divider. Bit 18 always reads back 0. The match word, the enables and the backup word keep their values.
- R6: Status bit 1 (tick flag) is set on every counter tick.
- R7: Status bit 0 (match flag) is set on the tick whose new count equals the match word. It never sets while the match word is all ones.
- R8: A read of the status word (address 3) returns the flags and then clears them. A flag event in the same cycle as the read leaves that flag set.
- R9: irq is high exactly when (status bit 0 and mode bit 16) or (status bit 1 and mode bit 17).
- R10: The backup word (address 4) is fully readable and writable and survives counter restarts.
- R11: Word addresses are mode 0, match 1, count 2, status 3, backup 4. Other addresses read 0. Read data appears on bus_rdata in the cycle after bus_rd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, runs all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Slow reference clock, sampled as data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The divider is driven with ratios of 3, 5, 2, 1 and 0, using counted bursts of slow edges. Counts that land just short of and exactly on a multiple of the ratio separate a correct divide from an off-by-one. A mode rewrite in the middle of a ratio period shows whether the divider really restarts. A ratio of 0 separates the 65536 reading from a divide by one. The match and tick enables are tried alone and together, before and after status reads. This tells a gated, level-held interrupt from an ungated one and from one that fails to clear on read.

// File: rtl/sec_timer_pkg.sv
package sec_timer_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 3;
    localparam int MATCH_BIT   = 0;
    localparam int TICK_BIT    = 1;
    localparam int EN_SHIFT    = 16;
    localparam int RESTART_BIT = 18;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE   = 3'd0,
        REG_MATCH  = 3'd1,
        REG_COUNT  = 3'd2,
        REG_STATUS = 3'd3,
        REG_BACKUP = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        EDGE_ARM  = 2'd0,
        EDGE_LOW  = 2'd1,
        EDGE_HIGH = 2'd2
    } edge_state_e;
endpackage

// File: rtl/sec_slow_sync.sv
module sec_slow_sync
    import sec_timer_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_in,
    output logic edge_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              level;
    edge_state_e       state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], slow_in};
    end

    assign level = sync_q[STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDGE_ARM;
        else        state_q <= state_d;
    end

    // next state and output
    always_comb begin
        state_d    = state_q;
        edge_pulse = 1'b0;
        unique case (state_q)
            EDGE_ARM:  if (!level) state_d = EDGE_LOW;
            EDGE_LOW:  if (level) begin
                           state_d    = EDGE_HIGH;
                           edge_pulse = 1'b1;
                       end
            EDGE_HIGH: if (!level) state_d = EDGE_LOW;
            default:   state_d = EDGE_ARM;
        endcase
    end
endmodule

// File: rtl/sec_divider.sv
module sec_divider #(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               edge_pulse,
    input  logic               restart,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    localparam int DIV_W = PRESC_W + 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;
    logic [DIV_W-1:0] last;

    // zero in the field stands for the full 2**PRESC_W ratio
    assign limit = (presc == '0) ? {1'b1, {PRESC_W{1'b0}}} : {1'b0, presc};
    assign last  = limit - 1'b1;
    assign tick  = edge_pulse && !restart && (div_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          div_q <= '0;
        else if (restart)    div_q <= '0;
        else if (edge_pulse) div_q <= (div_q == last) ? '0 : div_q + 1'b1;
    end
endmodule

// File: rtl/sec_count_core.sv
module sec_count_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] match_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             match_flag,
    output logic             tick_flag
);
    logic [CNT_W-1:0] next_cnt;
    logic             hit;

    assign next_cnt = count + 1'b1;
    assign hit      = tick && (match_val != '1) && (next_cnt == match_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (tick)  count <= next_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_flag <= 1'b0;
            tick_flag  <= 1'b0;
        end else begin
            match_flag <= (match_flag && !flag_clr) || hit;
            tick_flag  <= (tick_flag && !flag_clr) || tick;
        end
    end
endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
    import sec_timer_pkg::*;
#(
    parameter int PRESC_W     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PRESC_RESET = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic               edge_pulse;
    logic               div_tick;
    logic               mode_wr;
    logic               cnt_clear;
    logic               status_rd;
    logic [PRESC_W-1:0] presc_q;
    logic               match_en_q;
    logic               tick_en_q;
    logic [DATA_W-1:0]  match_q;
    logic [DATA_W-1:0]  backup_q;
    logic [DATA_W-1:0]  cnt_value;
    logic               match_flag;
    logic               tick_flag;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  unused_wbits;

    assign mode_wr   = bus_wr && (bus_addr == REG_MODE);
    assign cnt_clear = mode_wr && bus_wdata[RESTART_BIT];
    assign status_rd = bus_rd && (bus_addr == REG_STATUS);
    assign unused_wbits = bus_wdata;

    sec_slow_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_in    (slow_clk),
        .edge_pulse (edge_pulse)
    );

    sec_divider #(.PRESC_W(PRESC_W)) i_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_pulse (edge_pulse),
        .restart    (mode_wr),
        .presc      (presc_q),
        .tick       (div_tick)
    );

    sec_count_core #(.CNT_W(DATA_W)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (div_tick),
        .clear      (cnt_clear),
        .match_val  (match_q),
        .flag_clr   (status_rd),
        .count      (cnt_value),
        .match_flag (match_flag),
        .tick_flag  (tick_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q    <= PRESC_W'(PRESC_RESET);
            match_en_q <= 1'b0;
            tick_en_q  <= 1'b0;
            match_q    <= '1;
            backup_q   <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                REG_MODE: begin
                    presc_q    <= bus_wdata[PRESC_W-1:0];
                    match_en_q <= bus_wdata[EN_SHIFT + MATCH_BIT];
                    tick_en_q  <= bus_wdata[EN_SHIFT + TICK_BIT];
                end
                REG_MATCH:  match_q  <= bus_wdata;
                REG_BACKUP: backup_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            REG_MODE: begin
                rd_mux[PRESC_W-1:0]          = presc_q;
                rd_mux[EN_SHIFT + MATCH_BIT] = match_en_q;
                rd_mux[EN_SHIFT + TICK_BIT]  = tick_en_q;
            end
            REG_MATCH:  rd_mux = match_q;
            REG_COUNT:  rd_mux = cnt_value;
            REG_STATUS: begin
                rd_mux[MATCH_BIT] = match_flag;
                rd_mux[TICK_BIT]  = tick_flag;
            end
            REG_BACKUP: rd_mux = backup_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign irq = (match_flag && match_en_q) || (tick_flag && tick_en_q);
endmodule

// File: rtl/sec_alarm_timer_chk.sv
module sec_alarm_timer_chk
    import sec_timer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              div_tick,
    input logic              cnt_clear,
    input logic [DATA_W-1:0] cnt_value,
    input logic [DATA_W-1:0] match_q,
    input logic              match_flag,
    input logic              tick_flag,
    input logic              irq
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_value != $past(cnt_value)) |->
        ((cnt_value == $past(cnt_value) + 1'b1) || (cnt_value == '0)));

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (cnt_value == '0));

    // R6
    tick_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |=> tick_flag);

    // R7
    match_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> ($past(match_q) != '1));

    // R8
    status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == REG_STATUS) && !div_tick) |=> (!match_flag && !tick_flag));

    // R8
    status_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == REG_STATUS) && div_tick) |=> tick_flag);

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (match_flag || tick_flag));
endmodule

bind sec_alarm_timer sec_alarm_timer_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .div_tick   (div_tick),
    .cnt_clear  (cnt_clear),
    .cnt_value  (cnt_value),
    .match_q    (match_q),
    .match_flag (match_flag),
    .tick_flag  (tick_flag),
    .irq        (irq)
);

// File: tb/test_sec_alarm_timer.sv
module test_sec_alarm_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          checks = 0;
    int          failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_alarm_timer i_sec_alarm_timer (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_clk = 1'b1;
            repeat (2) @(negedge clk);
            slow_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic test_reset();
        logic [31:0] d;
        rd(3'd0, d); check("R1 mode", d, 32'h0000_8000);
        rd(3'd1, d); check("R1 match", d, 32'hFFFF_FFFF);
        rd(3'd2, d); check("R1 count", d, 32'h0);
        rd(3'd3, d); check("R1 status", d, 32'h0);
        rd(3'd4, d); check("R1 backup", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(3'd7, d); check("R11 unused addr", d, 32'h0);
    endtask

    task automatic test_divide();
        logic [31:0] d;
        wr(3'd0, 32'd3);
        pulses(7);
        rd(3'd2, d); check("R2 7 edges /3", d, 32'd2);
        rd(3'd3, d); check("R6 tick flag", d, 32'h2);
        rd(3'd3, d); check("R8 cleared", d, 32'h0);
        pulses(5);
        rd(3'd2, d); check("R2 12 edges /3", d, 32'd4);
        wr(3'd0, 32'd5);
        pulses(4);
        rd(3'd2, d); check("R2 /5 short", d, 32'd4);
        pulses(1);
        rd(3'd2, d); check("R2 /5 exact", d, 32'd5);
        wr(3'd0, 32'd3);
        pulses(2);
        wr(3'd0, 32'd3);
        pulses(2);
        rd(3'd2, d); check("R3 mode write restarts divider", d, 32'd5);
        pulses(1);
        rd(3'd2, d); check("R3 after restart", d, 32'd6);
    endtask

    task automatic test_zero_ratio();
        logic [31:0] d;
        wr(3'd0, 32'd0);
        pulses(10);
        rd(3'd2, d); check("R3 zero ratio", d, 32'd6);
    endtask

    task automatic test_count_ro();
        logic [31:0] d;
        wr(3'd2, 32'h1234);
        rd(3'd2, d); check("R4 count write ignored", d, 32'd6);
    endtask

    task automatic test_restart();
        logic [31:0] d;
        wr(3'd4, 32'hCAFE_F00D);
        wr(3'd1, 32'h50);
        wr(3'd0, 32'h0005_0002);
        rd(3'd2, d); check("R5 count cleared", d, 32'd0);
        rd(3'd0, d); check("R5 mode readback", d, 32'h0001_0002);
        rd(3'd1, d); check("R5 match kept", d, 32'h50);
        rd(3'd4, d); check("R10 backup kept", d, 32'hCAFE_F00D);
        rd(3'd3, d);
    endtask

    task automatic test_match();
        logic [31:0] d;
        wr(3'd1, 32'd3);
        pulses(5);
        check("R9 no irq before match", {31'b0, irq}, 32'h0);
        rd(3'd3, d); check("R7 no match yet", d, 32'h2);
        pulses(1);
        rd(3'd2, d); check("R7 count at match", d, 32'd3);
        check("R9 irq on match", {31'b0, irq}, 32'h1);
        rd(3'd3, d); check("R7 match flag", d, 32'h3);
        check("R9 irq dropped after read", {31'b0, irq}, 32'h0);
    endtask

    task automatic test_tick_irq();
        logic [31:0] d;
        wr(3'd0, 32'h0002_0001);
        rd(3'd3, d);
        check("R9 tick irq idle", {31'b0, irq}, 32'h0);
        pulses(1);
        check("R9 tick irq", {31'b0, irq}, 32'h1);
        rd(3'd3, d); check("R6 tick only", d, 32'h2);
        check("R9 tick irq cleared", {31'b0, irq}, 32'h0);
        wr(3'd0, 32'h0000_0001);
        pulses(1);
        check("R9 disabled irq", {31'b0, irq}, 32'h0);
        rd(3'd3, d); check("R6 flag without enable", d, 32'h2);
        rd(3'd4, d); check("R10 backup survives", d, 32'hCAFE_F00D);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        test_reset();
        test_divide();
        test_zero_ratio();
        test_count_ro();
        test_restart();
        test_match();
        test_tick_irq();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule